// File: doc/BRIEF.md
# Phase Lag Index Matrix Accumulator

This block turns a stream of per-channel instantaneous phase values into a pairwise phase-synchronization matrix. It takes one phase word per channel on every accepted sample strobe. For each unordered channel pair it adds the sign of the wrapped phase difference to a signed running sum. Once a window of a fixed power-of-two number of samples is complete, the block enters a finalization pass. That pass visits one pair per clock. For each pair it takes the magnitude of the sum, scales it to an unsigned fraction by a shift, and stores the result in a matrix memory.

Only the pairs with row below column are computed and stored. The read port folds a request for (row, column) onto the stored pair, so the matrix reads as symmetric. Diagonal reads and reads outside the channel range return zero. A one-cycle done pulse marks the point where the whole matrix holds the new window. The phase source upstream feeds the block, and graph analysis downstream reads the matrix through the read port.

Top module: `phase_lag_matrix`

## Requirements
- R1: After reset, done_o is low and every matrix read returns 0.
- R2: Channel c's phase is phase_i[c*PH_W +: PH_W], a two's-complement word where full scale spans minus to plus pi. For a pair with row r below column k, the step is d = (phase_r - phase_k) mod 2^PH_W. It is 0 when d is 0, -1 when the top bit of d is 1 (this includes d = 2^(PH_W-1)), and +1 otherwise.
- R3: A window is 2^WIN_LOG2 accepted strobes. The first accepted strobe of each window restarts every pair sum from that sample's step alone, so no earlier window carries over.
- R4: The stored value is |sum| * 2^(FRAC_W-WIN_LOG2), unsigned, FRAC_W+1 bits wide. A value of 2^FRAC_W means 1.0, and it is never exceeded.
- R5: After the edge that accepts the last sample of a window, the block writes one pair per cycle over NPAIRS = N_CH*(N_CH-1)/2 cycles. done_o is high for exactly one cycle, NPAIRS clock cycles after that accepting edge.
- R6: Strobes that arrive while finalization runs are ignored. They neither count toward the next window nor change any sum.
- R7: A read with row equal to column, or with either index at or above N_CH, returns 0.
- R8: A read of (k, r) with k above r returns the same value as a read of (r, k).
- R9: rd_data_o is registered and reflects the indices presented one cycle earlier. A stored entry keeps its value until the next finalization rewrites it.
- R10: No pair sum ever exceeds 2^WIN_LOG2 in magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_vld_i | input | 1 | Sample strobe |
| phase_i | input | N_CH*PH_W | Packed per-channel phase words |
| rd_row_i | input | $clog2(N_CH) | Read row index |
| rd_col_i | input | $clog2(N_CH) | Read column index |
| rd_data_o | output | FRAC_W+1 | Matrix entry, unsigned fraction |
| done_o | output | 1 | One-cycle pulse when the matrix is updated |

## Verification
The bench builds the block with 6 channels, 10-bit phases, a 16-sample window and 8 fractional bits. This gives 15 pairs, a finalization pass short enough to inject strobes into almost every cycle of it, and a shift of 4 at the output. A 16-sample window lets a directed pattern drive every sum to its full-scale value. It also keeps many random windows, with random gaps between strobes, inside a small cycle budget. A 3-bit index reaches two out-of-range rows and columns, so both the out-of-range fold and the zero-difference and half-turn sign cases are exercised.

// File: rtl/plm_pkg.sv
package plm_pkg;
  // linear slot of pair (r,k), r<k, in row-major upper-triangle order
  function automatic int unsigned pair_idx(int unsigned r, int unsigned k, int unsigned n);
    return r * n - (r * (r + 1)) / 2 + (k - r - 1);
  endfunction
endpackage

// File: rtl/plm_pair_lane.sv
module plm_pair_lane #(
  parameter int PH_W     = 12,
  parameter int WIN_LOG2 = 7,
  localparam int ACC_W   = WIN_LOG2 + 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    restart_i,
  input  logic [PH_W-1:0]         ph_a_i,
  input  logic [PH_W-1:0]         ph_b_i,
  output logic signed [ACC_W-1:0] acc_o
);
  localparam int LIM = 1 << WIN_LOG2;

  logic [PH_W-1:0]         diff;
  logic signed [1:0]       step;
  logic signed [ACC_W-1:0] step_x;
  logic signed [ACC_W-1:0] acc_q;

  always_comb begin
    diff = ph_a_i - ph_b_i;
    if (diff == '0)             step = 2'sd0;
    else if (diff[PH_W-1])      step = -2'sd1;
    else                        step = 2'sd1;
    step_x = {{(ACC_W-2){step[1]}}, step};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (en_i)   acc_q <= restart_i ? step_x : acc_q + step_x;
  end

  assign acc_o = acc_q;

  a_r10_acc_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q <= LIM) && (acc_q >= -LIM));
  a_r6_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(acc_q));
endmodule

// File: rtl/plm_window_ctrl.sv
module plm_window_ctrl #(
  parameter int WIN_LOG2 = 7,
  parameter int NPAIRS   = 171,
  localparam int PI_W    = $clog2(NPAIRS + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            smp_vld_i,
  output logic            acc_en_o,
  output logic            restart_o,
  output logic            wr_en_o,
  output logic [PI_W-1:0] wr_idx_o,
  output logic            done_o
);
  typedef enum logic {ST_ACC, ST_FIN} st_e;

  st_e                 st_q;
  logic [WIN_LOG2-1:0] cnt_q;
  logic [PI_W-1:0]     idx_q;
  logic                done_q;

  assign acc_en_o  = smp_vld_i && (st_q == ST_ACC);
  assign restart_o = (cnt_q == '0);
  assign wr_en_o   = (st_q == ST_FIN);
  assign wr_idx_o  = idx_q;
  assign done_o    = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_ACC;
      cnt_q  <= '0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st_q == ST_ACC) begin
        if (acc_en_o) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == '1) begin
            st_q  <= ST_FIN;
            idx_q <= '0;
          end
        end
      end else begin
        idx_q <= idx_q + 1'b1;
        if (idx_q == PI_W'(NPAIRS - 1)) begin
          st_q   <= ST_ACC;
          done_q <= 1'b1;
        end
      end
    end
  end

  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r5_done_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(wr_en_o));
endmodule

// File: rtl/plm_matrix_store.sv
module plm_matrix_store #(
  parameter int N_CH   = 19,
  parameter int OUT_W  = 9,
  parameter int NPAIRS = 171,
  localparam int PI_W  = $clog2(NPAIRS + 1),
  localparam int RW    = $clog2(N_CH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [PI_W-1:0]  wr_idx_i,
  input  logic [OUT_W-1:0] wr_data_i,
  input  logic [RW-1:0]    rd_row_i,
  input  logic [RW-1:0]    rd_col_i,
  output logic [OUT_W-1:0] rd_data_o
);
  logic [OUT_W-1:0] mem_q [NPAIRS];
  logic [OUT_W-1:0] rd_next, rd_q;
  int unsigned      lo, hi;

  always_comb begin
    rd_next = '0;
    lo = 32'(rd_row_i);
    hi = 32'(rd_col_i);
    if (rd_row_i > rd_col_i) begin
      lo = 32'(rd_col_i);
      hi = 32'(rd_row_i);
    end
    if (({1'b0, rd_row_i} < (RW+1)'(N_CH)) && ({1'b0, rd_col_i} < (RW+1)'(N_CH))
        && (rd_row_i != rd_col_i))
      rd_next = mem_q[PI_W'(plm_pkg::pair_idx(lo, hi, N_CH))];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NPAIRS; p++) mem_q[p] <= '0;
      rd_q <= '0;
    end else begin
      if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
      rd_q <= rd_next;
    end
  end

  assign rd_data_o = rd_q;

  a_r7_diag_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_row_i == rd_col_i) |=> (rd_data_o == '0));
endmodule

// File: rtl/phase_lag_matrix.sv
module phase_lag_matrix #(
  parameter int N_CH     = 19,
  parameter int PH_W     = 12,
  parameter int WIN_LOG2 = 7,
  parameter int FRAC_W   = 8,
  localparam int NPAIRS  = N_CH * (N_CH - 1) / 2,
  localparam int PI_W    = $clog2(NPAIRS + 1),
  localparam int RW      = $clog2(N_CH),
  localparam int ACC_W   = WIN_LOG2 + 2,
  localparam int MAG_W   = WIN_LOG2 + 1,
  localparam int OUT_W   = FRAC_W + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   smp_vld_i,
  input  logic [N_CH*PH_W-1:0]   phase_i,
  input  logic [RW-1:0]          rd_row_i,
  input  logic [RW-1:0]          rd_col_i,
  output logic [OUT_W-1:0]       rd_data_o,
  output logic                   done_o
);
  logic                    acc_en, restart, wr_en;
  logic [PI_W-1:0]         wr_idx;
  logic signed [ACC_W-1:0] acc_w [NPAIRS];
  logic signed [ACC_W-1:0] sel;
  logic [MAG_W-1:0]        mag;
  logic [OUT_W-1:0]        wr_data;

  plm_window_ctrl #(.WIN_LOG2(WIN_LOG2), .NPAIRS(NPAIRS)) u_ctrl (
    .clk_i, .rst_ni, .smp_vld_i,
    .acc_en_o(acc_en), .restart_o(restart),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .done_o(done_o)
  );

  for (genvar r = 0; r < N_CH - 1; r++) begin : g_row
    for (genvar k = r + 1; k < N_CH; k++) begin : g_col
      localparam int P = plm_pkg::pair_idx(r, k, N_CH);
      plm_pair_lane #(.PH_W(PH_W), .WIN_LOG2(WIN_LOG2)) u_lane (
        .clk_i, .rst_ni,
        .en_i(acc_en), .restart_i(restart),
        .ph_a_i(phase_i[r*PH_W +: PH_W]),
        .ph_b_i(phase_i[k*PH_W +: PH_W]),
        .acc_o(acc_w[P])
      );
    end
  end

  always_comb begin
    sel = acc_w[wr_idx];
    mag = sel[ACC_W-1] ? MAG_W'(-sel) : MAG_W'(sel);
  end

  // normalise by window length with a shift only
  if (FRAC_W >= WIN_LOG2) begin : g_shl
    assign wr_data = OUT_W'(mag) << (FRAC_W - WIN_LOG2);
  end else begin : g_shr
    assign wr_data = OUT_W'(mag >> (WIN_LOG2 - FRAC_W));
  end

  plm_matrix_store #(.N_CH(N_CH), .OUT_W(OUT_W), .NPAIRS(NPAIRS)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .rd_row_i, .rd_col_i, .rd_data_o
  );

  a_r4_full_scale: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> (wr_data <= OUT_W'(1 << FRAC_W)));
endmodule

// File: tb/sim_phase_lag_matrix.sv
module sim_phase_lag_matrix;
  localparam int N   = 6;
  localparam int PW  = 10;
  localparam int WL  = 4;
  localparam int FW  = 8;
  localparam int WIN = 1 << WL;
  localparam int NP  = N * (N - 1) / 2;
  localparam int RW  = $clog2(N);

  logic clk = 0, rst_n = 0, vld = 0, done;
  logic [N*PW-1:0] phase = '0;
  logic [RW-1:0] rrow = '0, rcol = '0;
  logic [FW:0] rdata;

  int n_chk = 0, n_err = 0;
  int acc_m [N][N];
  int smp_in_win = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  phase_lag_matrix #(.N_CH(N), .PH_W(PW), .WIN_LOG2(WL), .FRAC_W(FW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .smp_vld_i(vld), .phase_i(phase),
    .rd_row_i(rrow), .rd_col_i(rcol), .rd_data_o(rdata), .done_o(done)
  );

  function automatic int step_of(int a, int b);
    int d = (a - b) & ((1 << PW) - 1);
    if (d == 0) return 0;
    if (d >= (1 << (PW - 1))) return -1;
    return 1;
  endfunction

  function automatic int expect_of(int r, int k);
    int lo, hi, s;
    if (r >= N || k >= N || r == k) return 0;
    lo = (r < k) ? r : k;
    hi = (r < k) ? k : r;
    s = acc_m[lo][hi];
    if (s < 0) s = -s;
    return s << (FW - WL);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(int ph [N], int gap);
    repeat (gap) @(negedge clk);
    for (int c = 0; c < N; c++) phase[c*PW +: PW] = PW'(ph[c]);
    vld = 1;
    for (int r = 0; r < N; r++)
      for (int k = r + 1; k < N; k++) begin
        if (smp_in_win == 0) acc_m[r][k] = 0;
        acc_m[r][k] += step_of(ph[r], ph[k]);
      end
    smp_in_win = (smp_in_win + 1) % WIN;
    @(negedge clk);
    vld = 0;
  endtask

  task automatic read_at(int r, int k, output int v);
    @(negedge clk);
    rrow = RW'(r);
    rcol = RW'(k);
    @(negedge clk);
    v = int'(rdata);
  endtask

  // wait for done, injecting strobes during finalization when inject is set
  task automatic wait_done(bit inject);
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (done) break;
      if (cyc > 1000) begin
        check(0, "R5 watchdog", cyc, NP);
        break;
      end
      vld = inject ? 1'($urandom_range(0, 1)) : 1'b0;
      phase = {$urandom, $urandom};
    end
    vld = 0;
    check(cyc == NP, "R5 done latency", cyc, NP);
    @(negedge clk);
    check(done == 0, "R5 done single pulse", int'(done), 0);
  endtask

  task automatic read_all(string tag);
    int v, e;
    for (int r = 0; r < (1 << RW); r++)
      for (int k = 0; k < (1 << RW); k++) begin
        read_at(r, k, v);
        e = expect_of(r, k);
        if (r >= N || k >= N || r == k) check(v == e, {tag, " R7 zero entry"}, v, e);
        else if (r > k)                 check(v == e, {tag, " R8 mirrored"}, v, e);
        else                            check(v == e, {tag, " R4 value"}, v, e);
      end
  endtask

  initial begin
    int ph [N];
    int v, e;
    void'($urandom(32'd4711));
    for (int r = 0; r < N; r++) for (int k = 0; k < N; k++) acc_m[r][k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(done == 0, "R1 done low", int'(done), 0);
    read_all("R1 reset");

    // full scale: every difference negative -> all sums at -WIN
    for (int s = 0; s < WIN; s++) begin
      for (int c = 0; c < N; c++) ph[c] = c * 100 + s;
      send(ph, 0);
    end
    wait_done(0);
    read_all("R4 full scale");

    // zero difference, half turn, alternating signs; strobes injected in finalization (R6)
    for (int s = 0; s < WIN; s++) begin
      ph[0] = 7; ph[1] = 7;
      ph[2] = 0; ph[3] = 512;
      ph[4] = (s % 2) ? 5 : -5; ph[5] = 0;
      send(ph, s % 3);
    end
    wait_done(1);
    read_all("R2 R6 directed");

    // R9: mid-window reads still see previous matrix
    for (int s = 0; s < WIN / 2; s++) begin
      for (int c = 0; c < N; c++) ph[c] = int'($urandom_range(0, (1 << PW) - 1));
      send(ph, 0);
    end
    read_at(0, 1, v);
    check(v == 0, "R9 hold during window", v, 0);
    read_at(3, 2, v);
    check(v == (WIN << (FW - WL)), "R9 hold during window", v, WIN << (FW - WL));
    for (int s = WIN / 2; s < WIN; s++) begin
      for (int c = 0; c < N; c++) ph[c] = int'($urandom_range(0, (1 << PW) - 1));
      send(ph, int'($urandom_range(0, 2)));
    end
    wait_done(1);
    read_all("R3 random");

    // more random windows, biased phases to vary sums
    for (int w = 0; w < 5; w++) begin
      for (int s = 0; s < WIN; s++) begin
        for (int c = 0; c < N; c++)
          ph[c] = (w % 2) ? int'($urandom_range(0, 60)) + c * 40 : int'($urandom_range(0, (1 << PW) - 1));
        send(ph, int'($urandom_range(0, 2)));
      end
      wait_done(w % 2);
      read_all("R3 R6 random");
    end

    // R7 direct diagonal read right after writing
    read_at(4, 4, v);
    e = 0;
    check(v == e, "R7 diagonal", v, e);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule